// File: doc/BRIEF.md
# Scratch Register Bus Self-Test Sequencer

This block checks, on demand, that a register bus really stores and returns data. A start pulse sets off a fixed program of eight transactions on a request port that allows one transaction at a time. The program targets two scratch registers. It writes a different 32-bit test word into each, then reads both back and checks the low 32 bits of each returned word. It then repeats the same four transactions with the two words swapped. A bus that only echoes the last written value, or whose registers already hold the right words from an earlier run, therefore cannot pass.

The program stops at the first read that does not match. At the end a one-cycle done pulse reports the verdict. A pass flag and a step code identify which of the four read checks failed. Both stay on the outputs until the next start. The test words are 32'h01234567 (word A) and 32'hFEDCBA98 (word B). Each is written zero-extended into the low field of a bus word that is `DATA_W` bits wide.

Top module: `scratch_selftest`

## Requirements
- R1: While reset is high and in the cycle after it, busy, done, pass, req_valid and fail_code are all 0.
- R2: A start pulse seen while idle raises busy at the next clock edge. At the same edge it presents the first request: a write to `REG0_ADDR` whose data is word A zero-extended.
- R3: A fully passing run issues exactly eight transactions in this order: write A to reg0, write B to reg1, read reg0, read reg1, write B to reg0, write A to reg1, read reg0, read reg1.
- R4: A request holds req_valid, req_write, req_addr and req_wdata steady until a clock edge at which req_ready is high. While a read is waiting for rsp_valid, no new request is presented.
- R5: Only bits [31:0] of rsp_rdata are compared. Any value in the upper bits has no effect on the verdict.
- R6: When all four reads match, done pulses, pass is 1 and fail_code is 0.
- R7: At the first mismatching read the run stops with no further request. Done pulses with pass 0 and fail_code giving the read position: 1 = first read of reg0, 2 = first read of reg1, 3 = second read of reg0, 4 = second read of reg1.
- R8: Done lasts one cycle and busy is already 0 in that cycle. Pass and fail_code keep their values until the next accepted start.
- R9: A start pulse that arrives while busy is ignored. The run carries on unchanged and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a self-test run (accepted only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Verdict of the last run, 1 = all reads matched |
| fail_code | output | 3 | 0 on pass, else 1..4 = failing read position |
| req_valid | output | 1 | Bus request present |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Register address of the request |
| req_wdata | output | DATA_W | Write data |
| req_ready | input | 1 | Bus accepts the request at this edge |
| rsp_valid | input | 1 | Read data is valid |
| rsp_rdata | input | DATA_W | Read data |

## Verification
Two events can share one cycle: the done pulse ending a run and a fresh start pulse. Because busy is already low during done, a start driven in exactly that cycle must be taken and must begin a complete new run. The bench drives start in the sampled done cycle and judges the follow-on run by its first request and full transaction order. The reverse case is a start driven while busy, including cycles where the bus is stalling or a read is outstanding. That start must leave the transaction sequence untouched, and the outputs must stay idle after the verdict.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] WORD_A = 32'h0123_4567;
  localparam logic [WORD_W-1:0] WORD_B = 32'hFEDC_BA98;
  localparam int STEPS  = 8;
  localparam int STEP_W = $clog2(STEPS);
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} sst_state_e;

  typedef struct packed {
    logic              is_read;
    logic              reg_sel;
    logic [WORD_W-1:0] word;
    logic [CODE_W-1:0] code;
  } sst_op_t;
endpackage

// File: rtl/sst_step_table.sv
module sst_step_table
  import sst_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output sst_op_t           op
);
  // step[2] selects the swapped pass, step[1] read half, step[0] register
  logic swap_pass;
  assign swap_pass = step[2];

  always_comb begin
    op.is_read = step[1];
    op.reg_sel = step[0];
    op.word    = (step[0] ^ swap_pass) ? WORD_B : WORD_A;
    op.code    = {1'b0, swap_pass, step[0]} + CODE_W'(1);
  end
endmodule

// File: rtl/sst_compare.sv
module sst_compare
  import sst_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [WORD_W-1:0] expect_word,
  output logic              match
);
  assign match = (rdata[WORD_W-1:0] == expect_word);
endmodule

// File: rtl/scratch_selftest.sv
module scratch_selftest
  import sst_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 128,
  parameter logic [ADDR_W-1:0] REG0_ADDR = 'h20,
  parameter logic [ADDR_W-1:0] REG1_ADDR = 'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [CODE_W-1:0] fail_code,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata
);
  localparam int PAD_W = DATA_W - WORD_W;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  sst_state_e        state;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] nstep;
  sst_op_t           op_cur;
  sst_op_t           op_nxt;
  logic              rd_match;

  assign nstep = (state == ST_IDLE) ? '0 : step + STEP_W'(1);

  sst_step_table u_cur_tbl (.step(step),  .op(op_cur));
  sst_step_table u_nxt_tbl (.step(nstep), .op(op_nxt));

  sst_compare #(.DATA_W(DATA_W)) u_cmp (
    .rdata       (rsp_rdata),
    .expect_word (op_cur.word),
    .match       (rd_match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_code <= '0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            busy      <= 1'b1;
            pass      <= 1'b0;
            fail_code <= '0;
            step      <= nstep;
            req_valid <= 1'b1;
            req_write <= ~op_nxt.is_read;
            req_addr  <= op_nxt.reg_sel ? REG1_ADDR : REG0_ADDR;
            req_wdata <= op_nxt.is_read ? '0 : {{PAD_W{1'b0}}, op_nxt.word};
            state     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (req_ready) begin
            if (req_write) begin
              step      <= nstep;
              req_write <= ~op_nxt.is_read;
              req_addr  <= op_nxt.reg_sel ? REG1_ADDR : REG0_ADDR;
              req_wdata <= op_nxt.is_read ? '0 : {{PAD_W{1'b0}}, op_nxt.word};
            end else begin
              req_valid <= 1'b0;
              state     <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (!rd_match || step == LAST_STEP) begin
              done      <= 1'b1;
              busy      <= 1'b0;
              pass      <= rd_match;
              fail_code <= rd_match ? '0 : op_cur.code;
              state     <= ST_IDLE;
            end else begin
              step      <= nstep;
              req_valid <= 1'b1;
              req_write <= ~op_nxt.is_read;
              req_addr  <= op_nxt.reg_sel ? REG1_ADDR : REG0_ADDR;
              req_wdata <= op_nxt.is_read ? '0 : {{PAD_W{1'b0}}, op_nxt.word};
              state     <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sst_checker.sv
module sst_checker
  import sst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [CODE_W-1:0] fail_code,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              req_ready
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_write)
      && $stable(req_addr) && $stable(req_wdata));

  // R4
  req_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy);

  // R2
  first_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> req_valid && req_write && req_wdata[WORD_W-1:0] == WORD_A);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !req_valid);

  // R6
  pass_code_chk: assert property (@(posedge clk) disable iff (rst)
    done && pass |-> fail_code == '0);

  // R7
  fail_code_chk: assert property (@(posedge clk) disable iff (rst)
    done && !pass |-> fail_code >= CODE_W'(1) && fail_code <= CODE_W'(4));
endmodule

bind scratch_selftest sst_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sst_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .pass(pass),
  .fail_code(fail_code), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready)
);

// File: tb/test_scratch_selftest.sv
module test_scratch_selftest;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 128;
  localparam logic [ADDR_W-1:0] A0 = 'h20;
  localparam logic [ADDR_W-1:0] A1 = 'h21;
  localparam logic [31:0] WA = 32'h0123_4567;
  localparam logic [31:0] WB = 32'hFEDC_BA98;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, pass, req_valid, req_write;
  logic [2:0] fail_code;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic req_ready = 1'b0;
  logic rsp_valid = 1'b0;
  logic [DATA_W-1:0] rsp_rdata = '0;

  int checks = 0;
  int fails = 0;
  logic [DATA_W-1:0] mem0, mem1;
  logic [31:0] last_w;

  always #10 clk = ~clk;

  scratch_selftest #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG0_ADDR(A0), .REG1_ADDR(A1))
  i_scratch_selftest (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
    .fail_code(fail_code), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit e_read(int idx);  return (idx % 4) >= 2; endfunction
  function automatic bit e_reg(int idx);   return idx[0];         endfunction
  function automatic logic [31:0] e_word(int idx);
    return (e_reg(idx) ^ (idx >= 4)) ? WB : WA;
  endfunction

  // mode: 0 good, 1 echo last write, 2 corrupt read bad_rd, 4 reg1 ignores writes,
  //       5 good with all-ones upper bits
  task automatic do_run(input int mode, input int bad_rd, input bit prestarted,
                        input bit busy_start, input bit restart_after);
    int txn = 0, rd = 0, pending = 0, exp_code = 0, cycles = 0;
    bit seen_done = 0;
    logic [DATA_W-1:0] rdval = '0;
    logic [31:0] ew;
    mem0 = '0; mem1 = '0; last_w = '0;
    if (!prestarted) begin
      @(negedge clk); start = 1'b1;
    end
    while (!seen_done && cycles < 300) begin
      @(negedge clk);
      cycles++;
      start = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0; rsp_rdata = '0;
      if (cycles == 1) begin
        chk(busy && req_valid, "R2", "busy/req_valid after start", {busy, req_valid}, 2'b11);
        chk(req_write && req_addr == A0 && req_wdata == {96'd0, WA}, "R2", "first request",
            req_wdata, {96'd0, WA});
      end
      if (done) begin
        seen_done = 1;
        if (restart_after) start = 1'b1;
      end else begin
        if (busy_start && busy && (cycles % 3 == 0)) start = 1'b1;
        if (pending > 0) begin
          chk(!req_valid, "R4", "request while read outstanding", req_valid, 0);
          pending--;
          if (pending == 0) begin
            rsp_valid = 1'b1; rsp_rdata = rdval;
          end
        end else if (req_valid && ($urandom % 4 != 0)) begin
          req_ready = 1'b1;
          if (exp_code != 0) chk(0, "R7", "request after failing read", txn, rd);
          else if (txn >= 8) chk(0, "R3", "extra transaction", txn, 8);
          else begin
            chk(req_write == !e_read(txn), "R3", "transaction kind", req_write, !e_read(txn));
            chk(req_addr == (e_reg(txn) ? A1 : A0), "R3", "transaction address",
                req_addr, e_reg(txn) ? A1 : A0);
            if (!e_read(txn))
              chk(req_wdata == {96'd0, e_word(txn)}, "R3", "write data", req_wdata,
                  {96'd0, e_word(txn)});
          end
          if (req_write) begin
            if (req_addr == A0) mem0 = req_wdata;
            else if (mode != 4) mem1 = req_wdata;
            last_w = req_wdata[31:0];
          end else begin
            ew = e_word(txn);
            rdval[31:0] = (mode == 1) ? last_w : ((req_addr == A0) ? mem0[31:0] : mem1[31:0]);
            rdval[127:32] = (mode == 5) ? '1 : {$urandom, $urandom, $urandom};
            if (mode == 2 && rd == bad_rd) rdval[$urandom % 32] ^= 1'b1;
            if (exp_code == 0 && rdval[31:0] != ew) exp_code = rd + 1;
            rd++;
            pending = 1 + $urandom % 3;
          end
          txn++;
        end
      end
    end
    if (!seen_done) chk(0, "R6", "watchdog: run never finished", cycles, 0);
    else begin
      chk(pass == (exp_code == 0), (exp_code == 0) ? "R6" : "R7", "pass flag", pass, exp_code == 0);
      chk(fail_code == exp_code[2:0], "R7", "fail_code", fail_code, exp_code);
      chk(!busy, "R8", "busy low in done cycle", busy, 0);
      if (mode == 5) chk(pass, "R5", "upper read bits ignored", pass, 1);
      if (exp_code == 0) chk(txn == 8, "R3", "transaction count", txn, 8);
      if (!restart_after) begin
        repeat (3) @(negedge clk);
        chk(!done && !busy && !req_valid, "R9", "idle after run", {done, busy, req_valid}, 0);
        chk(pass == (exp_code == 0) && fail_code == exp_code[2:0], "R8", "verdict held",
            {pass, fail_code}, {exp_code == 0, exp_code[2:0]});
      end
    end
  endtask

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk({busy, done, pass, req_valid, fail_code} == '0, "R1", "outputs in reset",
        {busy, done, pass, req_valid, fail_code}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, pass, req_valid, fail_code} == '0, "R1", "outputs after reset",
        {busy, done, pass, req_valid, fail_code}, 0);
    do_run(0, 0, 0, 0, 0);   // R6 clean pass
    do_run(1, 0, 0, 0, 0);   // R7 echoing bus -> code 1
    do_run(4, 0, 0, 0, 0);   // R7 reg1 stuck -> code 2
    do_run(2, 2, 0, 0, 0);   // R7 code 3
    do_run(2, 3, 0, 0, 0);   // R7 code 4
    do_run(5, 0, 0, 0, 0);   // R5 upper bits all ones
    do_run(0, 0, 0, 1, 0);   // R9 start while busy
    do_run(0, 0, 0, 0, 1);   // start in the done cycle
    do_run(2, 1, 1, 0, 0);   // follow-on run must start by itself
    for (int i = 0; i < 20; i++) begin
      int m;
      m = $urandom % 3;
      do_run((m == 0) ? 0 : (m == 1) ? 2 : 5, $urandom % 4, 0, $urandom % 2, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule